// File: doc/BRIEF.md
# Exception-Aware Return Target Resolver

This block keeps the flag state and the code address state that a processor core needs to resolve where a subroutine return goes. It holds eight condition registers and eight code address registers. Integer ALU results and memory load results refresh the flags of a destination condition register. An exception raised by such an operation sets that register's exception flag. Calls store the address of the following instruction in the normal link register. Software loads the exception-handler link register and the other code address registers with explicit writes.

When a return is issued, the block reads one condition register and checks its exception flag. The return selects that register through its selector field, or condition register 0 when no selector is supplied. If the flag is set, the return goes to the exception-handler link. Otherwise it goes to the normal link. The resolved address appears one clock later, together with a marker telling which link was taken.

Slot 0 of the code address set always reads the live instruction pointer. Slot 7 captures the interrupted instruction pointer when an interrupt is taken.

The return path is a three-state machine:
- `ST_IDLE`: no target is presented.
- `ST_RET_NORMAL`: the target comes from the normal link.
- `ST_RET_EXC`: the target comes from the exception-handler link.

The transitions are:
- `go_normal`: a return whose flag is clear moves the machine from any state to `ST_RET_NORMAL`.
- `go_exc`: a return whose flag is set moves the machine from any state to `ST_RET_EXC`.
- `drop`: a cycle without a return moves the machine from any state back to `ST_IDLE`.

Top module: `ret_target_unit`

## Requirements
- R1: Each condition register reads as 8 bits. Bit 0 is exception, bit 1 is zero, bit 2 is negative and bit 3 is odd. Bits 7:4 always read 0.
- R2: An accepted update of kind ALU (`upd_kind`=0) or load (`upd_kind`=1) writes the destination condition register on the next edge. Zero is set when the result equals 0. Negative is the result MSB. Odd is result bit 0.
- R3: Updates of kind vector (`upd_kind`=2) or branch (`upd_kind`=3) leave every condition register unchanged, even when `upd_exc` is high.
- R4: An ALU or load update writes its exception bit from `upd_exc`. The bit is 1 when an exception was reported and 0 otherwise.
- R5: A call writes `call_next_pc` into code address slot 1, the normal link. A call wins over a same-cycle manual write to slot 1.
- R6: A manual write stores `lw_data` into slots 1 to 7, and slot 2 is the exception-handler link. Writes to slot 0 are ignored. Reading slot 0 returns `ip_in`.
- R7: When `int_take` is high, slot 7 captures `ip_in`. This capture wins over a same-cycle manual write to slot 7.
- R8: A return in cycle N gives `tgt_valid`=1 in cycle N+1, using register state from before the edge that ends cycle N. The target is slot 2 with `tgt_from_exc`=1 if the selected exception bit is set. Otherwise it is slot 1 with `tgt_from_exc`=0. `tgt_valid` is 0 in every cycle that does not follow a return.
- R9: With `ret_use_sel`=0, a return uses condition register 0 and ignores `ret_sel`.
- R10: Reset clears all condition registers and code address slots 1 to 7 to zero, and drives `tgt_valid` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Flag update request |
| upd_kind | input | 2 | 0 ALU, 1 load, 2 vector, 3 branch |
| upd_cr | input | 3 | Destination condition register |
| upd_result | input | DW | Operation result |
| upd_exc | input | 1 | Exception reported for this operation |
| call_valid | input | 1 | Call command |
| call_next_pc | input | AW | Address after the call |
| lw_valid | input | 1 | Manual code address write |
| lw_idx | input | 3 | Slot to write |
| lw_data | input | AW | Value to write |
| int_take | input | 1 | Interrupt taken, capture `ip_in` into slot 7 |
| ip_in | input | AW | Current instruction pointer |
| ret_valid | input | 1 | Return command |
| ret_use_sel | input | 1 | 1: use `ret_sel`, 0: use condition register 0 |
| ret_sel | input | 3 | Condition register for the return |
| cr_rd_idx | input | 3 | Condition register read index |
| cr_rd_data | output | 8 | Condition register read data |
| ca_rd_idx | input | 3 | Code address read index |
| ca_rd_data | output | AW | Code address read data |
| tgt_valid | output | 1 | Resolved return target valid |
| tgt_addr | output | AW | Resolved return target |
| tgt_from_exc | output | 1 | Target came from the exception-handler link |

## Verification
The checker watches several behaviours on every cycle:
- the zero upper nibble of every condition register read;
- the one-cycle return latency, and the absence of any target when no return was issued;
- the link write made by a call;
- the live instruction pointer at slot 0;
- that vector and branch updates leave flags unchanged;
- that a reported exception raises the flag.

Other behaviours can only be shown by the bench's scenarios:
- which link a return picks after a sequence of flag updates and link writes;
- that condition register 0 is chosen when no selector is given;
- the priorities of call and interrupt capture over manual writes.

The bench checks these against a reference model of all sixteen registers.

// File: rtl/ret_target_pkg.sv
package ret_target_pkg;
    localparam int NUM_CR   = 8;
    localparam int NUM_CA   = 8;
    localparam int CR_W     = 8;
    localparam int SEL_W    = $clog2(NUM_CR);
    localparam int CA_SEL_W = $clog2(NUM_CA);

    // flag bit positions
    localparam int F_EXC  = 0;
    localparam int F_ZERO = 1;
    localparam int F_NEG  = 2;
    localparam int F_ODD  = 3;

    // fixed code address slots
    localparam int SLOT_IP   = 0;
    localparam int SLOT_LINK = 1;
    localparam int SLOT_EXCL = 2;
    localparam int SLOT_IIP  = 7;

    typedef enum logic [1:0] {
        K_ALU    = 2'd0,
        K_LOAD   = 2'd1,
        K_VECTOR = 2'd2,
        K_BRANCH = 2'd3
    } upd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE       = 2'd0,
        ST_RET_NORMAL = 2'd1,
        ST_RET_EXC    = 2'd2
    } ret_state_e;
endpackage

// File: rtl/cond_reg_file.sv
module cond_reg_file
    import ret_target_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic [1:0]       upd_kind,
    input  logic [SEL_W-1:0] upd_cr,
    input  logic [DW-1:0]    upd_result,
    input  logic             upd_exc,
    input  logic [SEL_W-1:0] rd_idx,
    output logic [CR_W-1:0]  rd_data,
    input  logic [SEL_W-1:0] ret_idx,
    output logic             ret_exc
);
    logic [3:0] flags [NUM_CR];
    logic [3:0] new_flags;
    logic       writes_flags;

    always_comb begin
        writes_flags        = upd_valid &&
                              (upd_kind == K_ALU || upd_kind == K_LOAD);
        new_flags           = '0;
        new_flags[F_EXC]    = upd_exc;
        new_flags[F_ZERO]   = (upd_result == '0);
        new_flags[F_NEG]    = upd_result[DW-1];
        new_flags[F_ODD]    = upd_result[0];
    end

    for (genvar g = 0; g < NUM_CR; g++) begin : g_cr
        always_ff @(posedge clk) begin
            if (!rst_n)
                flags[g] <= '0;
            else if (writes_flags && upd_cr == SEL_W'(g))
                flags[g] <= new_flags;
        end
    end

    assign rd_data = {{(CR_W-4){1'b0}}, flags[rd_idx]};
    assign ret_exc = flags[ret_idx][F_EXC];
endmodule

// File: rtl/code_addr_file.sv
module code_addr_file
    import ret_target_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                call_valid,
    input  logic [AW-1:0]       call_next_pc,
    input  logic                lw_valid,
    input  logic [CA_SEL_W-1:0] lw_idx,
    input  logic [AW-1:0]       lw_data,
    input  logic                int_take,
    input  logic [AW-1:0]       ip_in,
    input  logic [CA_SEL_W-1:0] rd_idx,
    output logic [AW-1:0]       rd_data,
    output logic [AW-1:0]       link_norm,
    output logic [AW-1:0]       link_exc
);
    logic [AW-1:0] slots [NUM_CA];

    assign slots[SLOT_IP] = ip_in;

    for (genvar g = 1; g < NUM_CA; g++) begin : g_ca
        logic          hw_hit;
        logic [AW-1:0] hw_val;
        if (g == SLOT_LINK) begin : g_link
            assign hw_hit = call_valid;
            assign hw_val = call_next_pc;
        end else if (g == SLOT_IIP) begin : g_iip
            assign hw_hit = int_take;
            assign hw_val = ip_in;
        end else begin : g_plain
            assign hw_hit = 1'b0;
            assign hw_val = '0;
        end

        logic [AW-1:0] q;
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (hw_hit)
                q <= hw_val;
            else if (lw_valid && lw_idx == CA_SEL_W'(g))
                q <= lw_data;
        end
        assign slots[g] = q;
    end

    assign rd_data   = slots[rd_idx];
    assign link_norm = slots[SLOT_LINK];
    assign link_exc  = slots[SLOT_EXCL];
endmodule

// File: rtl/ret_resolve_fsm.sv
module ret_resolve_fsm
    import ret_target_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ret_valid,
    input  logic          sel_exc,
    input  logic [AW-1:0] link_norm,
    input  logic [AW-1:0] link_exc,
    output logic          tgt_valid,
    output logic [AW-1:0] tgt_addr,
    output logic          tgt_from_exc
);
    ret_state_e    state, state_nx;
    logic [AW-1:0] held_addr;

    always_comb begin
        unique case (state)
            ST_IDLE, ST_RET_NORMAL, ST_RET_EXC: begin
                if (!ret_valid)   state_nx = ST_IDLE;        // drop
                else if (sel_exc) state_nx = ST_RET_EXC;     // go_exc
                else              state_nx = ST_RET_NORMAL;  // go_normal
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            held_addr <= '0;
        end else begin
            state <= state_nx;
            if (ret_valid)
                held_addr <= sel_exc ? link_exc : link_norm;
        end
    end

    always_comb begin
        tgt_valid    = 1'b0;
        tgt_from_exc = 1'b0;
        tgt_addr     = '0;
        unique case (state)
            ST_IDLE: ;
            ST_RET_NORMAL: begin
                tgt_valid = 1'b1;
                tgt_addr  = held_addr;
            end
            ST_RET_EXC: begin
                tgt_valid    = 1'b1;
                tgt_from_exc = 1'b1;
                tgt_addr     = held_addr;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ret_target_unit.sv
module ret_target_unit
    import ret_target_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd_valid,
    input  logic [1:0]          upd_kind,
    input  logic [SEL_W-1:0]    upd_cr,
    input  logic [DW-1:0]       upd_result,
    input  logic                upd_exc,
    input  logic                call_valid,
    input  logic [AW-1:0]       call_next_pc,
    input  logic                lw_valid,
    input  logic [CA_SEL_W-1:0] lw_idx,
    input  logic [AW-1:0]       lw_data,
    input  logic                int_take,
    input  logic [AW-1:0]       ip_in,
    input  logic                ret_valid,
    input  logic                ret_use_sel,
    input  logic [SEL_W-1:0]    ret_sel,
    input  logic [SEL_W-1:0]    cr_rd_idx,
    output logic [CR_W-1:0]     cr_rd_data,
    input  logic [CA_SEL_W-1:0] ca_rd_idx,
    output logic [AW-1:0]       ca_rd_data,
    output logic                tgt_valid,
    output logic [AW-1:0]       tgt_addr,
    output logic                tgt_from_exc
);
    logic [SEL_W-1:0] ret_idx;
    logic             sel_exc;
    logic [AW-1:0]    link_norm, link_exc;

    assign ret_idx = ret_use_sel ? ret_sel : '0;

    cond_reg_file #(.DW(DW)) i_crf (
        .clk(clk), .rst_n(rst_n),
        .upd_valid(upd_valid), .upd_kind(upd_kind), .upd_cr(upd_cr),
        .upd_result(upd_result), .upd_exc(upd_exc),
        .rd_idx(cr_rd_idx), .rd_data(cr_rd_data),
        .ret_idx(ret_idx), .ret_exc(sel_exc)
    );

    code_addr_file #(.AW(AW)) i_caf (
        .clk(clk), .rst_n(rst_n),
        .call_valid(call_valid), .call_next_pc(call_next_pc),
        .lw_valid(lw_valid), .lw_idx(lw_idx), .lw_data(lw_data),
        .int_take(int_take), .ip_in(ip_in),
        .rd_idx(ca_rd_idx), .rd_data(ca_rd_data),
        .link_norm(link_norm), .link_exc(link_exc)
    );

    ret_resolve_fsm #(.AW(AW)) i_fsm (
        .clk(clk), .rst_n(rst_n),
        .ret_valid(ret_valid), .sel_exc(sel_exc),
        .link_norm(link_norm), .link_exc(link_exc),
        .tgt_valid(tgt_valid), .tgt_addr(tgt_addr), .tgt_from_exc(tgt_from_exc)
    );
endmodule

// File: rtl/ret_target_unit_chk.sv
module ret_target_unit_chk
    import ret_target_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 32
) (
    input logic                clk,
    input logic                rst_n,
    input logic                upd_valid,
    input logic [1:0]          upd_kind,
    input logic [SEL_W-1:0]    upd_cr,
    input logic                upd_exc,
    input logic                call_valid,
    input logic [AW-1:0]       call_next_pc,
    input logic [AW-1:0]       ip_in,
    input logic                ret_valid,
    input logic [SEL_W-1:0]    cr_rd_idx,
    input logic [CR_W-1:0]     cr_rd_data,
    input logic [CA_SEL_W-1:0] ca_rd_idx,
    input logic [AW-1:0]       ca_rd_data,
    input logic                tgt_valid
);
    a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        cr_rd_data[7:4] == 4'b0);

    a_r8_ret_latency: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |=> tgt_valid);

    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !ret_valid |=> !tgt_valid);

    a_r5_call_link: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(call_valid) && $past(rst_n) && ca_rd_idx == CA_SEL_W'(SLOT_LINK))
        |-> ca_rd_data == $past(call_next_pc));

    a_r6_ip_slot: assert property (@(posedge clk) disable iff (!rst_n)
        ca_rd_idx == CA_SEL_W'(SLOT_IP) |-> ca_rd_data == ip_in);

    a_r3_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_valid && upd_kind[1]) && $stable(cr_rd_idx))
        |-> $stable(cr_rd_data));

    a_r4_exc_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(upd_valid && !upd_kind[1] && upd_exc)
         && cr_rd_idx == $past(upd_cr))
        |-> cr_rd_data[F_EXC]);
endmodule

bind ret_target_unit ret_target_unit_chk #(.DW(DW), .AW(AW)) i_chk (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_kind(upd_kind), .upd_cr(upd_cr), .upd_exc(upd_exc),
    .call_valid(call_valid), .call_next_pc(call_next_pc), .ip_in(ip_in),
    .ret_valid(ret_valid),
    .cr_rd_idx(cr_rd_idx), .cr_rd_data(cr_rd_data),
    .ca_rd_idx(ca_rd_idx), .ca_rd_data(ca_rd_data),
    .tgt_valid(tgt_valid)
);

// File: tb/test_ret_target_unit.sv
module test_ret_target_unit;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          upd_valid, upd_exc;
    logic [1:0]    upd_kind;
    logic [2:0]    upd_cr;
    logic [DW-1:0] upd_result;
    logic          call_valid;
    logic [AW-1:0] call_next_pc;
    logic          lw_valid;
    logic [2:0]    lw_idx;
    logic [AW-1:0] lw_data;
    logic          int_take;
    logic [AW-1:0] ip_in;
    logic          ret_valid, ret_use_sel;
    logic [2:0]    ret_sel;
    logic [2:0]    cr_rd_idx, ca_rd_idx;
    logic [7:0]    cr_rd_data;
    logic [AW-1:0] ca_rd_data;
    logic          tgt_valid, tgt_from_exc;
    logic [AW-1:0] tgt_addr;

    int n_checks = 0;
    int n_fails  = 0;

    logic [7:0]    m_cr [8];
    logic [AW-1:0] m_ca [8];

    ret_target_unit #(.DW(DW), .AW(AW)) i_ret_target_unit (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] exp_flags(logic [DW-1:0] r, logic e);
        return {4'b0, r[0], r[DW-1], (r == '0), e};
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        upd_valid = 0; upd_kind = 0; upd_cr = 0; upd_result = 0; upd_exc = 0;
        call_valid = 0; call_next_pc = 0; lw_valid = 0; lw_idx = 0; lw_data = 0;
        int_take = 0; ret_valid = 0; ret_use_sel = 0; ret_sel = 0;
    endtask

    // Inputs are set at a negedge; this applies one edge, checks the
    // return output and updates the model.
    task automatic step(string req);
        logic          e_rv, e_exc;
        logic [AW-1:0] e_addr;
        logic [2:0]    idx;
        idx    = ret_use_sel ? ret_sel : 3'd0;
        e_rv   = ret_valid;
        e_exc  = m_cr[idx][0];
        e_addr = e_exc ? m_ca[2] : m_ca[1];
        @(posedge clk);
        #1;
        check({req, " R8 tgt_valid"}, 64'(tgt_valid), 64'(e_rv));
        if (e_rv) begin
            check({req, " R8 tgt_addr"}, 64'(tgt_addr), 64'(e_addr));
            check({req, " R8 tgt_from_exc"}, 64'(tgt_from_exc), 64'(e_exc));
        end
        if (upd_valid && !upd_kind[1]) m_cr[upd_cr] = exp_flags(upd_result, upd_exc);
        if (lw_valid && lw_idx != 0) m_ca[lw_idx] = lw_data;
        if (call_valid) m_ca[1] = call_next_pc;
        if (int_take) m_ca[7] = ip_in;
        @(negedge clk);
        idle_inputs();
    endtask

    task automatic read_all(string req);
        for (int i = 0; i < 8; i++) begin
            cr_rd_idx = 3'(i); ca_rd_idx = 3'(i);
            #1;
            check({req, " R1 cr read"}, 64'(cr_rd_data), 64'(m_cr[i]));
            check({req, " R6 ca read"}, 64'(ca_rd_data), i == 0 ? 64'(ip_in) : 64'(m_ca[i]));
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        idle_inputs();
        ip_in = 32'h1000; cr_rd_idx = 0; ca_rd_idx = 0;
        rst_n = 0;
        for (int i = 0; i < 8; i++) begin m_cr[i] = 0; m_ca[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        check("R10 tgt_valid after reset", 64'(tgt_valid), 0);
        read_all("R10 reset");

        // R2: zero / negative / odd
        upd_valid = 1; upd_kind = 0; upd_cr = 3; upd_result = 0; step("R2 zero");
        upd_valid = 1; upd_kind = 1; upd_cr = 4; upd_result = 32'h8000_0001; step("R2 neg odd");
        read_all("R2");
        // R3: vector and branch with exception leave flags alone
        upd_valid = 1; upd_kind = 2; upd_cr = 3; upd_result = 5; upd_exc = 1; step("R3 vector");
        upd_valid = 1; upd_kind = 3; upd_cr = 4; upd_result = 0; upd_exc = 1; step("R3 branch");
        read_all("R3");
        // R4: exception set, then cleared by a clean op
        upd_valid = 1; upd_kind = 0; upd_cr = 0; upd_result = 2; upd_exc = 1; step("R4 set");
        read_all("R4 set");
        // R5/R6: links
        call_valid = 1; call_next_pc = 32'hAAAA_0004; lw_valid = 1; lw_idx = 1; lw_data = 32'h5555;
        step("R5 call wins");
        lw_valid = 1; lw_idx = 2; lw_data = 32'hE000_0100; step("R6 excl");
        lw_valid = 1; lw_idx = 0; lw_data = 32'hDEAD; step("R6 slot0 ignored");
        // R7
        ip_in = 32'h0000_7770; int_take = 1; lw_valid = 1; lw_idx = 7; lw_data = 32'h1; step("R7 capture");
        ip_in = 32'h2000;
        read_all("R5 R6 R7");
        // R9/R8: default selector picks cr0 (exception set) although ret_sel points at a clear one
        ret_valid = 1; ret_use_sel = 0; ret_sel = 3; step("R9 default cr0");
        ret_valid = 1; ret_use_sel = 1; ret_sel = 3; step("R8 normal");
        // R8: return sees pre-edge state while clearing cr0 in same cycle
        ret_valid = 1; upd_valid = 1; upd_kind = 0; upd_cr = 0; upd_result = 1; step("R8 old state");
        ret_valid = 1; step("R4 cleared R8");
        step("R8 idle");

        for (int it = 0; it < 4000; it++) begin
            logic [31:0] r;
            r = $urandom;
            ip_in = $urandom;
            upd_valid = r[0]; upd_kind = r[2:1]; upd_cr = r[5:3];
            upd_exc = r[6];
            upd_result = r[8:7] == 0 ? 0 : $urandom;
            call_valid = r[9] & r[10];
            call_next_pc = $urandom;
            lw_valid = r[11]; lw_idx = r[14:12]; lw_data = $urandom;
            int_take = r[15] & r[16] & r[17];
            ret_valid = r[18]; ret_use_sel = r[19]; ret_sel = r[22:20];
            step("random");
            if (r[25:23] == 0) read_all("random");
        end
        read_all("final");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule